// File: doc/BRIEF.md
# Real-Time-Clock Alarm Compare and Interrupt Flags

This block sits beside a real-time-clock calendar counter. At each completed once-per-second update it compares the new hour, minute and second against three alarm bytes. It also collects three kinds of event into one flag byte: update done, alarm hit and periodic tick. The flag byte carries a master interrupt bit. An active-high interrupt line follows that master bit. Software programs the alarm bytes and the interrupt-enable byte through a small byte-wide write port. It acknowledges interrupts by reading the flag byte, which clears it.

An alarm byte whose two top bits are both 1 is a wildcard. That field then matches any time value. The comparison uses the time values exactly as the counter stores them after the update, in whatever number format the counter uses.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset the flag byte reads 0x00 and `irq` is low. All enable bits are cleared, so events that follow set their flags but do not raise `irq`.
- R2: Each cycle with `upd_done` high sets flag bit 4 (update flag) on the next clock edge.
- R3: With `upd_done` high, flag bit 5 (alarm flag) is set on the next edge only when all three fields match. The second compares with the byte at address 0x1, the minute with 0x3 and the hour with 0x5. A single mismatching field leaves bit 5 clear.
- R4: An alarm byte with bits 7:6 equal to 2'b11 matches any value of its field. With all three bytes set this way, bit 5 is set at every update.
- R5: Each cycle with `per_tick` high sets flag bit 6 (periodic flag) on the next edge.
- R6: Enable bits 6, 5 and 4 of the control byte at address 0xB pair with flag bits 6, 5 and 4. When a flag goes from 0 to 1 while its enable is 1, flag bit 7 and `irq` go high on the next edge. A flag that is set while its enable is 0 leaves bit 7 and `irq` unchanged.
- R7: `flags` always shows the flag byte. A cycle with `flag_rd` high clears every bit on the next edge and drops `irq`.
- R8: An event in the same cycle as `flag_rd` is not lost. Its flag is set after the clear, and `irq` is raised again if that flag is enabled.
- R9: Writes to address 0xC or 0xD leave the flag byte and `irq` unchanged.
- R10: A write to address 0xB sets bit 7 and `irq` on the next edge if any written enable bit (6:4) pairs with a flag that is set. If none does, the write clears bit 7 and lowers `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_done | input | 1 | One-cycle strobe: the once-per-second time update has completed |
| cur_sec | input | 8 | Stored seconds value after the update |
| cur_min | input | 8 | Stored minutes value after the update |
| cur_hour | input | 8 | Stored hours value after the update |
| per_tick | input | 1 | One-cycle strobe from the periodic divider |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| flag_rd | input | 1 | Read-and-clear strobe for the flag byte |
| flags | output | 8 | Flag byte: bit 7 master, 6 periodic, 5 alarm, 4 update, 3:0 zero |
| irq | output | 1 | Active-high interrupt request |

## Verification
Every result is registered. A strobe, a write or a read in one cycle shows up on `flags` and `irq` one clock edge later, and no earlier. The bench drives each cycle's inputs just after a rising edge. It works out the expected flag byte for the next edge from a model of its own, then compares one time unit after that edge. A long run of random strobes, reads and writes is mixed with directed cases: wildcard alarms, a single mismatching field, an event that coincides with a read, a re-enable onto a pending flag, and writes to the read-only addresses.

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_done,
  input  logic [DW-1:0] cur_sec,
  input  logic [DW-1:0] cur_min,
  input  logic [DW-1:0] cur_hour,
  input  logic          per_tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          flag_rd,
  output logic [DW-1:0] flags,
  output logic          irq
);
  localparam logic [AW-1:0] A_ASEC  = AW'(4'h1);
  localparam logic [AW-1:0] A_AMIN  = AW'(4'h3);
  localparam logic [AW-1:0] A_AHOUR = AW'(4'h5);
  localparam logic [AW-1:0] A_CTL   = AW'(4'hB);

  logic [DW-1:0] alm_s, alm_m, alm_h, ctl;
  logic [2:0]    ev_pending;
  logic          master;

  function automatic logic fld_hit(input logic [DW-1:0] alm, input logic [DW-1:0] cur);
    return (alm[DW-1:DW-2] == 2'b11) || (alm == cur);
  endfunction

  logic hit, ctl_wr;
  logic [2:0] ev, en_now, base, pend_nx;
  logic master_nx;

  assign hit    = fld_hit(alm_s, cur_sec) && fld_hit(alm_m, cur_min) && fld_hit(alm_h, cur_hour);
  assign ctl_wr = wr_en && (wr_addr == A_CTL);
  assign ev     = {per_tick, upd_done && hit, upd_done};
  assign en_now = ctl_wr ? wr_data[6:4] : ctl[6:4];
  assign base   = flag_rd ? 3'b000 : ev_pending;
  assign pend_nx = base | ev;

  always_comb begin
    master_nx = flag_rd ? 1'b0 : master;
    if (|(ev & ~base & en_now)) master_nx = 1'b1;
    if (ctl_wr) master_nx = |(wr_data[6:4] & pend_nx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_s <= '0;
      alm_m <= '0;
      alm_h <= '0;
      ctl <= '0;
      ev_pending <= '0;
      master <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_ASEC)  alm_s <= wr_data;
      if (wr_en && wr_addr == A_AMIN)  alm_m <= wr_data;
      if (wr_en && wr_addr == A_AHOUR) alm_h <= wr_data;
      if (ctl_wr) ctl <= wr_data;
      ev_pending <= pend_nx;
      master <= master_nx;
    end
  end

  assign flags = {master, ev_pending, {(DW-4){1'b0}}};
  assign irq   = master;

  a_r2_update_flag: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> flags[4]);
  a_r5_periodic_flag: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |=> flags[6]);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !upd_done && !per_tick) |=> (flags == '0 && !irq));
  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags[6:4] != 3'b000));
  a_r9_readonly_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == AW'(4'hC) || wr_addr == AW'(4'hD)) && !upd_done && !per_tick && !flag_rd)
    |=> ($stable(flags) && $stable(irq)));
  a_r8_event_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && upd_done) |=> flags[4]);
endmodule

// File: tb/rtc_alarm_irq_bench.sv
module rtc_alarm_irq_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic upd_done = 0, per_tick = 0, wr_en = 0, flag_rd = 0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, wr_data = 0;
  logic [3:0] wr_addr = 0;
  logic [7:0] flags;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_as = 0, m_am = 0, m_ah = 0, m_ctl = 0, m_flags = 0;

  always #(PERIOD/2) clk = ~clk;

  rtc_alarm_irq u_rtc_alarm_irq (
    .clk(clk), .rst_n(rst_n), .upd_done(upd_done), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hour(cur_hour), .per_tick(per_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag_rd(flag_rd), .flags(flags), .irq(irq)
  );

  function automatic bit f_match(input logic [7:0] a, input logic [7:0] c);
    return (a[7] && a[6]) || a == c;
  endfunction

  function automatic logic [7:0] f_next(input bit u, input bit t, input bit rd,
      input bit w, input logic [3:0] ad, input logic [7:0] d,
      input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h);
    logic [2:0] evs, en, old, nf;
    logic mb;
    evs = {t, u && f_match(m_as, s) && f_match(m_am, mi) && f_match(m_ah, h), u};
    en  = (w && ad == 4'hB) ? d[6:4] : m_ctl[6:4];
    old = rd ? 3'b0 : m_flags[6:4];
    nf  = old | evs;
    mb  = rd ? 1'b0 : m_flags[7];
    for (int i = 0; i < 3; i++) if (evs[i] && !old[i] && en[i]) mb = 1'b1;
    if (w && ad == 4'hB) mb = |(d[6:4] & nf);
    return {mb, nf, 4'b0};
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    checks++;
    if (flags !== exp || irq !== exp[7]) begin
      errors++;
      $display("FAIL %s flags=%02h irq=%b expected flags=%02h irq=%b", tag, flags, irq, exp, exp[7]);
    end
  endtask

  task automatic step(input string tag, input bit u, input bit t, input bit rd,
      input bit w, input logic [3:0] ad, input logic [7:0] d,
      input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h);
    logic [7:0] exp;
    upd_done = u; per_tick = t; flag_rd = rd; wr_en = w; wr_addr = ad; wr_data = d;
    cur_sec = s; cur_min = mi; cur_hour = h;
    exp = f_next(u, t, rd, w, ad, d, s, mi, h);
    @(posedge clk); #1;
    m_flags = exp;
    if (w && ad == 4'h1) m_as = d;
    if (w && ad == 4'h3) m_am = d;
    if (w && ad == 4'h5) m_ah = d;
    if (w && ad == 4'hB) m_ctl = d;
    check(tag, exp);
    upd_done = 0; per_tick = 0; flag_rd = 0; wr_en = 0;
  endtask

  task automatic wr(input string tag, input logic [3:0] ad, input logic [7:0] d);
    step(tag, 0, 0, 0, 1, ad, d, 0, 0, 0);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0a1a);
    #(PERIOD*2 + 1);
    check("R1 reset", 8'h00);
    rst_n = 1'b1;
    #(PERIOD);
    // R1: events after reset set flags with no irq
    step("R1 no enables", 1, 1, 0, 0, 0, 0, 8'h05, 8'h06, 8'h07);
    if (irq !== 1'b0) begin errors++; $display("FAIL R1 irq=%b expected 0", irq); end
    checks++;
    // R7: read clears
    step("R7 read clears", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    // R3: exact match on all fields
    wr("R3 set sec", 4'h1, 8'h30);
    wr("R3 set min", 4'h3, 8'h15);
    wr("R3 set hour", 4'h5, 8'h09);
    step("R3 match", 1, 0, 0, 0, 0, 0, 8'h30, 8'h15, 8'h09);
    step("R7 clear", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    step("R3 minute mismatch", 1, 0, 0, 0, 0, 0, 8'h30, 8'h16, 8'h09);
    step("R2 update flag", 1, 0, 1, 0, 0, 0, 8'h31, 8'h15, 8'h09);
    // R4: wildcards
    wr("R4 wild sec", 4'h1, 8'hC0);
    wr("R4 wild min", 4'h3, 8'hFF);
    wr("R4 wild hour", 4'h5, 8'hC7);
    step("R4 every second a", 1, 0, 1, 0, 0, 0, 8'h12, 8'h59, 8'h23);
    step("R4 every second b", 1, 0, 1, 0, 0, 0, 8'h00, 8'h00, 8'h00);
    // R6: enabled alarm raises irq; disabled periodic does not
    wr("R6 enable alarm", 4'hB, 8'h20);
    step("R7 clear before R6", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    step("R6 periodic disabled", 0, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R6 alarm raises irq", 1, 0, 0, 0, 0, 0, 8'h01, 8'h02, 8'h03);
    // R9: writes to read-only bytes
    wr("R9 write C", 4'hC, 8'h00);
    wr("R9 write D", 4'hD, 8'hFF);
    // R10: enable pending flag and disable
    wr("R10 disable clears master", 4'hB, 8'h00);
    wr("R10 enable pending periodic", 4'hB, 8'h40);
    // R8: event coinciding with read
    step("R8 tick with read", 0, 1, 1, 0, 0, 0, 0, 0, 0);
    step("R7 final clear", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    idle("R7 idle");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      bit u, t, rd, w;
      logic [3:0] ad;
      logic [7:0] d;
      u  = ($urandom % 4) == 0;
      t  = ($urandom % 5) == 0;
      rd = ($urandom % 6) == 0;
      w  = ($urandom % 5) == 0;
      case ($urandom % 6)
        0: ad = 4'h1; 1: ad = 4'h3; 2: ad = 4'h5; 3: ad = 4'hB; 4: ad = 4'hC; default: ad = 4'hD;
      endcase
      d = (ad == 4'hB) ? 8'(($urandom % 8) << 4)
        : (($urandom % 4) == 0 ? 8'hC0 : 8'($urandom % 3));
      step("R6 random", u, t, rd, w, ad, d, 8'($urandom % 3), 8'($urandom % 3), 8'($urandom % 3));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule